// File: doc/BRIEF.md
# Screen-Window Write Shadow Buffer

This block listens, without taking part, to the cycles of an 8-bit processor bus with a 16-bit address. It picks out every write cycle whose address falls in a 1 KB screen window, which by default runs from 0x0400 up to and including 0x07FF. For each such write it keeps the 10-bit offset inside the window and the data byte. The processor never waits on the block and is never told about it.

Captured writes go into a small asynchronous FIFO. That FIFO carries them from the processor clock to a display clock that comes from a separate oscillator. The video timing offers write slots on the display side. In each offered slot the block commits at most one queued write to a private display RAM, driving address, data and a write enable. The FIFO soaks up bursts of back-to-back writes. A single holding latch would lose the second write of such a burst.

When the queue is full, a new matching write is dropped. A sticky flag records the loss, and only a processor-side reset clears it.

Top module: `scrwr_shadow`

## Requirements
- R1: A bus cycle with `cpu_rnw` = 1 (read) is never captured, whatever its address.
- R2: A write is captured only if its address lies in 0x0400..0x07FF. Writes to 0x03FF, 0x0800, 0x0000 and 0xFFFF produce no display RAM write.
- R3: The display RAM address is the captured address minus 0x0400. Its 10 significant bits sit in the low bits and the upper bits of the 12-bit `dram_addr` are zero. The written byte equals the captured data.
- R4: Captured writes reach the display RAM in the order the processor issued them, each exactly once, with no duplicates.
- R5: `dram_we` is high only in the display cycle that follows a display clock edge at which `disp_slot` was high. At most one write is committed per slot.
- R6: Four back-to-back window writes issued while no slot is offered are all held and later committed.
- R7: A window write that arrives while four entries are waiting is dropped and sets `overflow_seen`. The flag stays set after the queue drains.
- R8: While the reset inputs are low, and right after reset, `dram_we` = 0 and `overflow_seen` = 0. A processor-side reset clears a set `overflow_seen`.
- R9: Once slots are offered again, every held entry is committed within a bounded number of display cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor bus clock; one bus cycle per rising edge |
| cpu_rst_n | input | 1 | Synchronous active-low reset, processor domain |
| cpu_addr | input | 16 | Bus address |
| cpu_data | input | 8 | Bus data |
| cpu_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| disp_clk | input | 1 | Display clock |
| disp_rst_n | input | 1 | Synchronous active-low reset, display domain |
| disp_slot | input | 1 | High in a display cycle that may carry a RAM write |
| dram_addr | output | 12 | Display RAM write address |
| dram_data | output | 8 | Display RAM write data |
| dram_we | output | 1 | Display RAM write enable |
| overflow_seen | output | 1 | Sticky flag: a window write was dropped on a full queue |

## Verification
If a queue pointer is wrong, or the Gray-code crossing is corrupt, the fault appears at the next committed write. The bench sees a write whose address or data differs from the head of its model queue, a write with nothing expected, or a write that never comes before the drain deadline. A wrong full or empty decision shows up within one burst. The overflow flag then differs from the model on the next processor cycle, or an extra or missing commit appears once slots resume. A bad window decode shows up as a write for an address outside the window.

// File: rtl/scrwr_pkg.sv
// Package: shared widths and the queue entry type for the screen-window
// write shadow. Assumes a 16-bit bus address and a 1 KB window.
package scrwr_pkg;
    localparam int ADDR_W = 16;
    localparam int OFS_W  = 10;
    localparam int DAT_W  = 8;

    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        logic [DAT_W-1:0] dat;
    } entry_t;

    localparam int ENTRY_W = OFS_W + DAT_W;
endpackage

// File: rtl/scrwr_sync.sv
// Module: multi-stage synchronizer for a Gray-coded vector.
// Assumes only one bit of the input changes between destination edges.
module scrwr_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Shift the vector one stage deeper into the destination domain.
            always_ff @(posedge clk) begin
                if (!rst_n) st[i] <= '0;
                else if (i == 0) st[i] <= d;
                else st[i] <= st[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = st[STAGES-1];
endmodule

// File: rtl/scrwr_afifo.sv
// Module: asynchronous FIFO with Gray-coded pointers between the processor
// (write) and display (read) clocks. DEPTH must be a power of two, >= 4.
// Read data is shown combinationally for the entry at the read pointer.
module scrwr_afifo
    import scrwr_pkg::*;
#(
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic   wclk,
    input  logic   wrst_n,
    input  logic   push,
    input  entry_t wdata,
    output logic   full,
    input  logic   rclk,
    input  logic   rrst_n,
    input  logic   pop,
    output entry_t rdata,
    output logic   empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    entry_t        mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rq_gray, wq_gray;
    logic [PW-1:0] wbin_nx, rbin_nx;

    assign wbin_nx = wbin + PW'(push);
    assign rbin_nx = rbin + PW'(pop);

    // Store the pushed entry at the write pointer.
    always_ff @(posedge wclk) begin
        if (push) mem[wbin[AW-1:0]] <= wdata;
    end

    // Advance the write pointer in binary and Gray form.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= bin2gray(wbin_nx);
        end
    end

    // Advance the read pointer in binary and Gray form.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= bin2gray(rbin_nx);
        end
    end

    scrwr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rq_gray));
    scrwr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wq_gray));

    assign full  = (wgray == {~rq_gray[PW-1:PW-2], rq_gray[PW-3:0]});
    assign empty = (rgray == wq_gray);
    assign rdata = mem[rbin[AW-1:0]];

    // R4: the write Gray pointer moves by at most one bit per edge.
    assert_wgray_step_R4: assert property (@(posedge wclk) disable iff (!wrst_n)
        $onehot0(wgray ^ $past(wgray)));
    // R4: the pointer seen in the read domain also moves one bit at a time.
    assert_wq_step_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
        $onehot0(wq_gray ^ $past(wq_gray)));
    // R6: fill level against the synchronized read pointer never exceeds DEPTH.
    assert_fill_bound_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
        (PW'(wbin - gray2bin(rq_gray)) <= PW'(DEPTH)));
endmodule

// File: rtl/scrwr_capture.sv
// Module: processor-side window decoder. Samples one bus cycle per cpu_clk
// edge, pushes window writes into the FIFO and keeps a sticky drop flag.
module scrwr_capture
    import scrwr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DAT_W-1:0]  data,
    input  logic              rnw,
    input  logic              full,
    output logic              push,
    output entry_t            entry,
    output logic              ovf
);
    logic hit;

    assign hit       = !rnw && (addr[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W]);
    assign push      = hit && !full;
    assign entry.ofs = addr[OFS_W-1:0];
    assign entry.dat = data;

    // Remember any window write lost to a full queue until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf <= 1'b0;
        else if (hit && full) ovf <= 1'b1;
    end

    // R7: the drop flag never clears on its own.
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    // R7: a matching write on a full queue raises the flag.
    assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && full) |=> ovf);
endmodule

// File: rtl/scrwr_commit.sv
// Module: display-side committer. In each offered slot with data waiting,
// registers one entry onto the display RAM write port.
module scrwr_commit
    import scrwr_pkg::*;
#(
    parameter int RAM_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot,
    input  logic              empty,
    input  entry_t            head,
    output logic              pop,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DAT_W-1:0]  ram_data,
    output logic              ram_we
);
    assign pop = slot && !empty;

    // Drive the RAM port for one cycle per consumed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we   <= 1'b0;
            ram_addr <= '0;
            ram_data <= '0;
        end else begin
            ram_we <= pop;
            if (pop) begin
                ram_addr <= RAM_AW'(head.ofs);
                ram_data <= head.dat;
            end
        end
    end

    // R5: no RAM write in a cycle that followed an edge without a slot.
    assert_we_in_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !slot |=> !ram_we);
    // R3: address bits above the window offset stay zero on every write.
    assert_zero_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr >> OFS_W) == '0);
endmodule

// File: rtl/scrwr_shadow.sv
// Module: top of the screen-window write shadow. Watches a processor bus,
// queues window writes across clocks and commits them in display slots.
// Assumes each cpu_clk rising edge marks one complete bus cycle.
module scrwr_shadow #(
    parameter logic [15:0] WIN_BASE    = 16'h0400,
    parameter int          DEPTH       = 4,
    parameter int          SYNC_STAGES = 2,
    parameter int          RAM_AW      = 12
) (
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_rnw,
    input  logic              disp_clk,
    input  logic              disp_rst_n,
    input  logic              disp_slot,
    output logic [RAM_AW-1:0] dram_addr,
    output logic [7:0]        dram_data,
    output logic              dram_we,
    output logic              overflow_seen
);
    import scrwr_pkg::*;

    logic   push, full, pop, empty;
    entry_t wentry, rentry;

    scrwr_capture #(.WIN_BASE(WIN_BASE)) u_cap (
        .clk(cpu_clk), .rst_n(cpu_rst_n), .addr(cpu_addr), .data(cpu_data),
        .rnw(cpu_rnw), .full(full), .push(push), .entry(wentry),
        .ovf(overflow_seen));

    scrwr_afifo #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_fifo (
        .wclk(cpu_clk), .wrst_n(cpu_rst_n), .push(push), .wdata(wentry),
        .full(full), .rclk(disp_clk), .rrst_n(disp_rst_n), .pop(pop),
        .rdata(rentry), .empty(empty));

    scrwr_commit #(.RAM_AW(RAM_AW)) u_com (
        .clk(disp_clk), .rst_n(disp_rst_n), .slot(disp_slot), .empty(empty),
        .head(rentry), .pop(pop), .ram_addr(dram_addr), .ram_data(dram_data),
        .ram_we(dram_we));
endmodule

// File: tb/sim_scrwr_shadow.sv
// Bench: behavioural queue model of the shadow buffer, compared on every
// display clock (RAM port) and every processor clock (drop flag).
module sim_scrwr_shadow;
    logic        cpu_clk = 0, disp_clk = 0;
    logic        cpu_rst_n = 0, disp_rst_n = 0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rnw = 1;
    logic        disp_slot = 0;
    logic [11:0] dram_addr;
    logic [7:0]  dram_data;
    logic        dram_we, overflow_seen;

    int checks = 0, fails = 0;
    int slot_mode = 0;      // 0 none, 1 every cycle, 2 every third cycle
    int slot_ph = 0;
    int commits = 0;
    int disp_cycles = 0;
    bit model_ovf = 0;
    bit done = 0;
    logic [17:0] q[$];      // {offset, data}

    always #13 cpu_clk = ~cpu_clk;   // separate processor oscillator
    always #10 disp_clk = ~disp_clk; // 50 MHz display clock

    scrwr_shadow u0 (.*);

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Offer display write slots according to the current mode.
    always @(negedge disp_clk) begin
        slot_ph = (slot_ph + 1) % 3;
        disp_slot <= (slot_mode == 1) || (slot_mode == 2 && slot_ph == 0);
    end

    // Compare the RAM port to the model queue once per display cycle.
    always @(posedge disp_clk) begin
        automatic bit slot_seen = disp_slot;
        automatic bit in_rst = !disp_rst_n;
        disp_cycles++;
        #5;
        if (in_rst) begin
            if (dram_we) check(0, "R8", dram_we, 0);
        end else if (dram_we) begin
            commits++;
            check(slot_seen, "R5", slot_seen, 1);
            if (q.size() == 0) begin
                check(0, "R4", {dram_addr, dram_data}, 0);
            end else begin
                automatic logic [17:0] e = q.pop_front();
                check(dram_addr == {2'b00, e[17:8]}, "R3", dram_addr, {2'b00, e[17:8]});
                check(dram_data == e[7:0], "R4", dram_data, e[7:0]);
            end
        end
    end

    // Compare the drop flag to the model once per processor cycle.
    always @(posedge cpu_clk) begin
        #3;
        if (cpu_rst_n && overflow_seen !== model_ovf)
            check(0, "R7", overflow_seen, model_ovf);
    end

    // One bus cycle; the model is updated at the edge that samples it.
    task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic rnw);
        @(negedge cpu_clk);
        cpu_addr = a; cpu_data = d; cpu_rnw = rnw;
        @(posedge cpu_clk);
        if (!rnw && a >= 16'h0400 && a <= 16'h07FF) begin
            if (q.size() < 4) q.push_back({a[9:0], d});
            else model_ovf = 1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bus(16'h0000, 8'h00, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge cpu_clk);
        cpu_rst_n = 0; disp_rst_n = 0; cpu_rnw = 1;
        repeat (6) @(negedge disp_clk);
        repeat (2) @(negedge cpu_clk);
        model_ovf = 0;
        q.delete();
        cpu_rst_n = 1; disp_rst_n = 1;
        repeat (4) @(negedge cpu_clk);
    endtask

    initial begin : watchdog
        wait (disp_cycles > 100000);
        if (!done) begin
            check(0, "R9", disp_cycles, 100000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int c0;
        // R8: reset state.
        repeat (5) @(negedge disp_clk);
        check(dram_we == 0, "R8", dram_we, 0);
        check(overflow_seen == 0, "R8", overflow_seen, 0);
        do_reset();
        check(dram_we == 0 && overflow_seen == 0, "R8", {dram_we, overflow_seen}, 0);

        // R1/R2: reads and out-of-window writes leave the RAM port idle.
        slot_mode = 1;
        c0 = commits;
        bus(16'h0500, 8'h11, 1'b1);
        bus(16'h0400, 8'h22, 1'b1);
        idle(2);
        bus(16'h03FF, 8'h33, 1'b0);
        bus(16'h0800, 8'h44, 1'b0);
        bus(16'h0000, 8'h55, 1'b0);
        bus(16'hFFFF, 8'h66, 1'b0);
        idle(20);
        check(commits == c0, "R1", commits - c0, 0);
        check(commits == c0, "R2", commits - c0, 0);

        // R3/R4: window edges and a middle address, spaced writes.
        c0 = commits;
        bus(16'h0400, 8'hA1, 1'b0); idle(3);
        bus(16'h07FF, 8'hB2, 1'b0); idle(3);
        bus(16'h0555, 8'hC3, 1'b0); idle(3);
        bus(16'h06AA, 8'hD4, 1'b0); idle(20);
        check(commits - c0 == 4, "R4", commits - c0, 4);
        check(q.size() == 0, "R9", q.size(), 0);

        // R6: bursts of four back-to-back writes against sparse slots.
        slot_mode = 2;
        c0 = commits;
        for (int b = 0; b < 3; b++) begin
            for (int i = 0; i < 4; i++) bus(16'h0410 + 16'(b*4+i), 8'(8'h30 + b*4+i), 1'b0);
            idle(25);
        end
        check(commits - c0 == 12, "R6", commits - c0, 12);
        check(q.size() == 0, "R9", q.size(), 0);
        check(overflow_seen == 0, "R7", overflow_seen, 0);

        // R7: five writes with no slots; the fifth is dropped.
        slot_mode = 0;
        idle(10);
        c0 = commits;
        for (int i = 0; i < 5; i++) bus(16'h0600 + 16'(i), 8'(8'hE0 + i), 1'b0);
        idle(20);
        check(commits == c0, "R5", commits - c0, 0);
        check(overflow_seen == 1, "R7", overflow_seen, 1);
        check(q.size() == 4, "R6", q.size(), 4);
        slot_mode = 1;
        idle(20);
        check(commits - c0 == 4, "R9", commits - c0, 4);
        check(q.size() == 0, "R9", q.size(), 0);
        check(overflow_seen == 1, "R7", overflow_seen, 1);

        // R8: processor reset clears the flag; block still works after it.
        do_reset();
        check(overflow_seen == 0, "R8", overflow_seen, 0);
        c0 = commits;
        bus(16'h0401, 8'h5A, 1'b0);
        idle(15);
        check(commits - c0 == 1, "R4", commits - c0, 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule